// File: doc/BRIEF.md
# CAN controller interrupt flag unit

This block collects the interrupt sources of a CAN-style controller into one 32-bit register of sticky flags. Event pulses and status levels arrive from the receive queues, the transmit path, the error counters and the message-memory logic. The block turns each of them into a flag that stays set until the processor clears it by writing a one to that bit. A few flags are derived rather than copied. The protocol-error flags screen a 3-bit last-error code. The bus-off, warning and passive flags fire on any change of their status level. The lost-element flags also fire when a write is attempted into a queue whose configured size is zero.

Software reaches the unit through a plain register port with a combinational read path. It holds four word registers: the flags at offset 0x50, a per-bit enable at 0x54, a per-bit line select at 0x58, and a mode register at 0x5C whose bit 0 is the restricted-operation mode. A line-select bit of 0 routes the flag to line 0, and a 1 routes it to line 1. Each of the two interrupt lines is registered. A transmit-side memory access failure sets the access-failure flag and also forces restricted mode on. That mode stays on until software writes a 0 to mode bit 0. The reset input is assumed to be synchronised to the clock upstream.

Top module: `can_irq_unit`

## Requirements
- R1: After reset, the flag, enable, line-select and mode registers all read 0, and irq_line and restricted_mode are 0.
- R2: Flag i sets when src_evt[i] goes from 0 to 1, for i in {0..19, 22, 26, 29}. A src_evt level held high does not set the flag again after it is cleared. src_evt bits 20, 21, 23, 24, 25, 27, 28, 30 and 31 have no effect.
- R3: A write to offset 0x50 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. Bits 20, 21, 30 and 31 of the flag, enable and line-select registers always read 0, and writes to them have no effect. A read with bus_sel low, or at an unused or unaligned address, returns 0.
- R4: When a set condition and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R5: Flag 27 sets when lec_arb changes to a value other than 0 or 7. Flag 28 does the same for lec_data. An unchanged code does not set the flag again.
- R6: Flags 25, 24 and 23 set on every change, in either direction, of st_bus_off, st_warn and st_passive respectively.
- R7: Flags 3, 7 and 15 set when the condition q_wr_try[q] AND q_size_zero[q] goes from 0 to 1, for q = 0, 1 and 2 respectively. A write attempt into a queue whose size is not zero does not set the flag.
- R8: A rising edge of tx_mem_fail sets flag 17 and sets restricted_mode. restricted_mode then stays 1 until a write to 0x5C with data bit 0 equal to 0. A failure edge in the same cycle as that write keeps the mode set.
- R9: In the cycle after a flag becomes visible, irq_line[L] equals the OR, over all bits, of flag AND enable, taken over the bits whose line-select value is L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_evt | input | 32 | Plain event conditions, one per flag position |
| q_wr_try | input | 3 | Write attempt into receive queue 0, receive queue 1, event queue |
| q_size_zero | input | 3 | Configured size of that queue is zero |
| lec_arb | input | 3 | Last error code, arbitration phase |
| lec_data | input | 3 | Last error code, data phase |
| st_bus_off | input | 1 | Bus-off status level |
| st_warn | input | 1 | Error-warning status level |
| st_passive | input | 1 | Error-passive status level |
| tx_mem_fail | input | 1 | Transmit-side memory access failure |
| irq_line | output | 2 | Registered interrupt lines 0 and 1 |
| restricted_mode | output | 1 | Restricted-operation mode |

## Verification
A wrong edge-detector history shows up in the next register read: a flag is missing, or a flag reappears after a clear while its source is still held high. A wrong code screen or a wrong status-change compare shows up the same way. A wrong flag, enable or select bit reaches irq_line one cycle later, because the lines are registered from the flag register. A lost or spurious restricted-mode state is visible on restricted_mode right after the clock edge that should have changed it. The bench compares irq_line and restricted_mode after every edge against a model built from the requirements. It reads the registers back under both directed and random traffic.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int REG_W = 32;
  localparam int LEC_W = 3;
  localparam int NUM_Q = 3;
  localparam int NUM_LINES = 2;

  // flags that follow a plain source edge
  localparam logic [REG_W-1:0] PLAIN_MASK = 32'h244F_FFFF;
  // every implemented flag position
  localparam logic [REG_W-1:0] VALID_MASK = 32'h3FCF_FFFF;

  localparam int BIT_MEM_FAIL  = 17;
  localparam int BIT_PASSIVE   = 23;
  localparam int BIT_WARN      = 24;
  localparam int BIT_BUSOFF    = 25;
  localparam int BIT_PERR_ARB  = 27;
  localparam int BIT_PERR_DATA = 28;

  localparam int OFS_FLAGS = 'h50;
  localparam int OFS_EN    = 'h54;
  localparam int OFS_LSEL  = 'h58;
  localparam int OFS_MODE  = 'h5C;

  typedef enum logic [2:0] {
    RID_NONE,
    RID_FLAGS,
    RID_EN,
    RID_LSEL,
    RID_MODE
  } reg_id_t;

  function automatic int lost_bit(input int q);
    case (q)
      0:       return 3;
      1:       return 7;
      default: return 15;
    endcase
  endfunction

endpackage

// File: rtl/can_irq_detect.sv
module can_irq_detect
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src_evt,
  input  logic [NUM_Q-1:0] q_wr_try,
  input  logic [NUM_Q-1:0] q_size_zero,
  input  logic [LEC_W-1:0] lec_arb,
  input  logic [LEC_W-1:0] lec_data,
  input  logic             st_bus_off,
  input  logic             st_warn,
  input  logic             st_passive,
  input  logic             tx_mem_fail,
  output logic [REG_W-1:0] set_vec,
  output logic             tx_fail_rise
);

  logic [REG_W-1:0] evt_prev_q;
  logic [NUM_Q-1:0] zq_now;
  logic [NUM_Q-1:0] zq_prev_q;
  logic [NUM_Q-1:0] zq_rise;
  logic [LEC_W-1:0] arb_prev_q;
  logic [LEC_W-1:0] data_prev_q;
  logic [2:0]       st_now;
  logic [2:0]       st_prev_q;
  logic             txf_prev_q;

  assign zq_now  = q_wr_try & q_size_zero;
  assign zq_rise = zq_now & ~zq_prev_q;
  assign st_now  = {st_bus_off, st_warn, st_passive};
  assign tx_fail_rise = tx_mem_fail & ~txf_prev_q;

  function automatic logic lec_hit(input logic [LEC_W-1:0] cur,
                                   input logic [LEC_W-1:0] prv);
    return (cur != prv) && (cur != '0) && (cur != '1);
  endfunction

  // history of every source, sampled each cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_prev_q  <= '0;
      zq_prev_q   <= '0;
      arb_prev_q  <= '0;
      data_prev_q <= '0;
      st_prev_q   <= '0;
      txf_prev_q  <= 1'b0;
    end else begin
      evt_prev_q  <= src_evt;
      zq_prev_q   <= zq_now;
      arb_prev_q  <= lec_arb;
      data_prev_q <= lec_data;
      st_prev_q   <= st_now;
      txf_prev_q  <= tx_mem_fail;
    end
  end

  always_comb begin
    set_vec = (src_evt & ~evt_prev_q) & PLAIN_MASK;
    for (int q = 0; q < NUM_Q; q++) begin
      if (zq_rise[q]) set_vec[lost_bit(q)] = 1'b1;
    end
    if (tx_fail_rise)                   set_vec[BIT_MEM_FAIL]  = 1'b1;
    if (st_now[2] != st_prev_q[2])      set_vec[BIT_BUSOFF]    = 1'b1;
    if (st_now[1] != st_prev_q[1])      set_vec[BIT_WARN]      = 1'b1;
    if (st_now[0] != st_prev_q[0])      set_vec[BIT_PASSIVE]   = 1'b1;
    if (lec_hit(lec_arb, arb_prev_q))   set_vec[BIT_PERR_ARB]  = 1'b1;
    if (lec_hit(lec_data, data_prev_q)) set_vec[BIT_PERR_DATA] = 1'b1;
  end

endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] flags_q
);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (VALID_MASK[i]) begin : g_impl
      logic bit_q;
      logic bit_nxt;
      logic bit_upd;

      assign bit_upd = set_vec[i] | clr_vec[i];

      // a set in the same cycle overrides the clear
      always_comb begin
        bit_nxt = bit_q;
        if (clr_vec[i]) bit_nxt = 1'b0;
        if (set_vec[i]) bit_nxt = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bit_q <= 1'b0;
        end else if (bit_upd) begin
          bit_q <= bit_nxt;
        end
      end

      assign flags_q[i] = bit_q;
    end else begin : g_rsvd
      assign flags_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/can_irq_regs.sv
module can_irq_regs
  import can_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  flags_q,
  input  logic              tx_fail_rise,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  clr_vec,
  output logic [REG_W-1:0]  en_q,
  output logic [REG_W-1:0]  sel_q,
  output logic              mode_q
);

  localparam int WORD_W = ADDR_W - 2;

  reg_id_t          rid;
  logic             wr_en;
  logic [REG_W-1:0] en_nxt;
  logic [REG_W-1:0] sel_nxt;
  logic             mode_nxt;
  logic             en_upd;
  logic             sel_upd;

  always_comb begin
    rid = RID_NONE;
    if (bus_sel && (bus_addr[1:0] == 2'b00)) begin
      case (bus_addr[ADDR_W-1:2])
        WORD_W'(OFS_FLAGS >> 2): rid = RID_FLAGS;
        WORD_W'(OFS_EN    >> 2): rid = RID_EN;
        WORD_W'(OFS_LSEL  >> 2): rid = RID_LSEL;
        WORD_W'(OFS_MODE  >> 2): rid = RID_MODE;
        default:                 rid = RID_NONE;
      endcase
    end
  end

  assign wr_en   = bus_sel & bus_wr;
  assign clr_vec = (wr_en && rid == RID_FLAGS) ? (bus_wdata & VALID_MASK) : '0;
  assign en_upd  = wr_en && (rid == RID_EN);
  assign sel_upd = wr_en && (rid == RID_LSEL);
  assign en_nxt  = bus_wdata & VALID_MASK;
  assign sel_nxt = bus_wdata & VALID_MASK;

  // hardware failure wins over a software clear of the mode
  always_comb begin
    mode_nxt = mode_q;
    if (wr_en && rid == RID_MODE) mode_nxt = bus_wdata[0];
    if (tx_fail_rise)             mode_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_upd) begin
      en_q <= en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_upd) begin
      sel_q <= sel_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
    end
  end

  always_comb begin
    case (rid)
      RID_FLAGS: bus_rdata = flags_q;
      RID_EN:    bus_rdata = en_q;
      RID_LSEL:  bus_rdata = sel_q;
      RID_MODE:  bus_rdata = {{(REG_W-1){1'b0}}, mode_q};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/can_irq_route.sv
module can_irq_route
  import can_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-1:0]     flags_q,
  input  logic [REG_W-1:0]     en_q,
  input  logic [REG_W-1:0]     sel_q,
  output logic [NUM_LINES-1:0] irq_q
);

  logic [REG_W-1:0]     armed;
  logic [NUM_LINES-1:0] line_nxt;

  assign armed = flags_q & en_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [REG_W-1:0] routed;
    if (l == 0) begin : g_l0
      assign routed = armed & ~sel_q;
    end else begin : g_l1
      assign routed = armed & sel_q;
    end
    assign line_nxt[l] = |routed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= line_nxt;
    end
  end

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       src_evt,
  input  logic [2:0]        q_wr_try,
  input  logic [2:0]        q_size_zero,
  input  logic [2:0]        lec_arb,
  input  logic [2:0]        lec_data,
  input  logic              st_bus_off,
  input  logic              st_warn,
  input  logic              st_passive,
  input  logic              tx_mem_fail,
  output logic [1:0]        irq_line,
  output logic              restricted_mode
);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flags_q;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] sel_q;
  logic             tx_fail_rise;

  can_irq_detect u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_evt      (src_evt),
    .q_wr_try     (q_wr_try),
    .q_size_zero  (q_size_zero),
    .lec_arb      (lec_arb),
    .lec_data     (lec_data),
    .st_bus_off   (st_bus_off),
    .st_warn      (st_warn),
    .st_passive   (st_passive),
    .tx_mem_fail  (tx_mem_fail),
    .set_vec      (set_vec),
    .tx_fail_rise (tx_fail_rise)
  );

  can_irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags_q (flags_q)
  );

  can_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .flags_q      (flags_q),
    .tx_fail_rise (tx_fail_rise),
    .bus_rdata    (bus_rdata),
    .clr_vec      (clr_vec),
    .en_q         (en_q),
    .sel_q        (sel_q),
    .mode_q       (restricted_mode)
  );

  can_irq_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_q (flags_q),
    .en_q    (en_q),
    .sel_q   (sel_q),
    .irq_q   (irq_line)
  );

endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk
  import can_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [2:0]        lec_arb,
  input logic              tx_mem_fail,
  input logic [1:0]        irq_line,
  input logic              restricted_mode,
  input logic [31:0]       flags_q,
  input logic [31:0]       en_q,
  input logic [31:0]       set_vec,
  input logic [31:0]       clr_vec
);

  logic mode_clear_wr;
  assign mode_clear_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_MODE)) && !bus_wdata[0];

  // R3: a flag drops only under a clearing write
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags_q) & ~$past(clr_vec)) & ~flags_q) == '0));

  // R3: reserved flag positions never hold a one
  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~VALID_MASK) == '0);

  // R4: every requested set is visible after the edge
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~flags_q) == '0));

  // R5: a new arbitration protocol error only follows a screened code
  p_lec_screen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[BIT_PERR_ARB]) |-> ($past(lec_arb) != 3'd0 && $past(lec_arb) != 3'd7));

  // R8: failure edge forces the mode and the access-failure flag
  p_txfail_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mem_fail) |=> (restricted_mode && flags_q[BIT_MEM_FAIL]));

  // R8: mode holds until software clears it
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (restricted_mode && !mode_clear_wr) |=> restricted_mode);

  // R9: a line is only raised by an enabled pending flag
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line != 2'b00) |-> ($past(flags_q & en_q) != '0));

endmodule

bind can_irq_unit can_irq_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_sel         (bus_sel),
  .bus_wr          (bus_wr),
  .bus_addr        (bus_addr),
  .bus_wdata       (bus_wdata),
  .lec_arb         (lec_arb),
  .tx_mem_fail     (tx_mem_fail),
  .irq_line        (irq_line),
  .restricted_mode (restricted_mode),
  .flags_q         (flags_q),
  .en_q            (en_q),
  .set_vec         (set_vec),
  .clr_vec         (clr_vec)
);

// File: tb/can_irq_unit_tb.sv
module can_irq_unit_tb;

  localparam int ADDR_W = 8;
  localparam logic [31:0] B_VALID = 32'h3FCF_FFFF;
  localparam logic [31:0] B_PLAIN = 32'h244F_FFFF;
  localparam logic [7:0] A_FLG = 8'h50, A_EN = 8'h54, A_SEL = 8'h58, A_MODE = 8'h5C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, src_evt;
  logic [2:0]  q_wr_try, q_size_zero, lec_arb, lec_data;
  logic        st_bus_off, st_warn, st_passive, tx_mem_fail;
  logic [1:0]  irq_line;
  logic        restricted_mode;

  can_irq_unit #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_evt(src_evt), .q_wr_try(q_wr_try), .q_size_zero(q_size_zero),
    .lec_arb(lec_arb), .lec_data(lec_data), .st_bus_off(st_bus_off),
    .st_warn(st_warn), .st_passive(st_passive), .tx_mem_fail(tx_mem_fail),
    .irq_line(irq_line), .restricted_mode(restricted_mode)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] m_flags, m_en, m_sel;
  logic        m_mode;
  logic [1:0]  m_irq;
  logic [31:0] p_evt;
  logic [2:0]  p_zq, p_st, p_arb, p_data;
  logic        p_txf;

  function automatic logic lec_bad(input logic [2:0] c, input logic [2:0] p);
    return (c != p) && (c != 3'd0) && (c != 3'd7);
  endfunction

  function automatic logic [31:0] model_set();
    logic [31:0] s;
    logic [2:0]  rise, st;
    s    = src_evt & ~p_evt & B_PLAIN;
    rise = (q_wr_try & q_size_zero) & ~p_zq;
    if (rise[0]) s[3] = 1'b1;
    if (rise[1]) s[7] = 1'b1;
    if (rise[2]) s[15] = 1'b1;
    if (tx_mem_fail && !p_txf) s[17] = 1'b1;
    st = {st_bus_off, st_warn, st_passive};
    if (st[2] != p_st[2]) s[25] = 1'b1;
    if (st[1] != p_st[1]) s[24] = 1'b1;
    if (st[0] != p_st[0]) s[23] = 1'b1;
    if (lec_bad(lec_arb, p_arb))   s[27] = 1'b1;
    if (lec_bad(lec_data, p_data)) s[28] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (!bus_sel) return 32'h0;
    case (a)
      A_FLG:   return m_flags;
      A_EN:    return m_en;
      A_SEL:   return m_sel;
      A_MODE:  return {31'h0, m_mode};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock: advance the model, then compare registered outputs
  task automatic cycle();
    logic [31:0] s, clr, nf, ne, ns;
    logic [1:0]  irq_n;
    logic        nm, w;
    s   = model_set();
    w   = bus_sel && bus_wr;
    clr = (w && bus_addr == A_FLG) ? (bus_wdata & B_VALID) : 32'h0;
    irq_n = {|(m_flags & m_en & m_sel), |(m_flags & m_en & ~m_sel)};
    nf = ((m_flags & ~clr) | s) & B_VALID;
    ne = (w && bus_addr == A_EN)  ? (bus_wdata & B_VALID) : m_en;
    ns = (w && bus_addr == A_SEL) ? (bus_wdata & B_VALID) : m_sel;
    nm = (w && bus_addr == A_MODE) ? bus_wdata[0] : m_mode;
    if (tx_mem_fail && !p_txf) nm = 1'b1;
    p_evt = src_evt; p_zq = q_wr_try & q_size_zero;
    p_st = {st_bus_off, st_warn, st_passive};
    p_arb = lec_arb; p_data = lec_data; p_txf = tx_mem_fail;
    @(posedge clk); #1;
    m_flags = nf; m_en = ne; m_sel = ns; m_mode = nm; m_irq = irq_n;
    chk("R9 irq_line", {30'h0, irq_line}, {30'h0, m_irq});
    chk("R8 restricted_mode", {31'h0, restricted_mode}, {31'h0, m_mode});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cycle();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    src_evt = 0; q_wr_try = 0; q_size_zero = 0; lec_arb = 0; lec_data = 0;
    st_bus_off = 0; st_warn = 0; st_passive = 0; tx_mem_fail = 0;
    m_flags = 0; m_en = 0; m_sel = 0; m_mode = 0; m_irq = 0;
    p_evt = 0; p_zq = 0; p_st = 0; p_arb = 0; p_data = 0; p_txf = 0;
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_line", {30'h0, irq_line}, 32'h0);
    chk("R1 restricted_mode", {31'h0, restricted_mode}, 32'h0);
    rd(A_FLG, "R1 flags"); chk("R1 flags literal", bus_rdata, 32'h0);
    rd(A_EN, "R1 enable"); rd(A_SEL, "R1 select"); rd(A_MODE, "R1 mode");
    idle(1);

    // R2 edge on a plain source, held level, ignored positions
    src_evt = 32'h0000_0001; idle(1);
    rd(A_FLG, "R2 flag0 set"); chk("R2 flag0 literal", bus_rdata, 32'h1);
    wr(A_FLG, 32'h1); idle(2);
    rd(A_FLG, "R2 held level no reset"); chk("R2 held literal", bus_rdata, 32'h0);
    src_evt = 32'hDB30_0000; idle(1); src_evt = 0; idle(1);
    rd(A_FLG, "R2 ignored src bits"); chk("R2 ignored literal", bus_rdata, 32'h0);
    src_evt = 32'h2440_0010; idle(1); src_evt = 0; idle(1);
    rd(A_FLG, "R2 upper map"); chk("R2 upper literal", bus_rdata, 32'h2440_0010);

    // R3 write-zero no effect, reserved bits
    wr(A_FLG, 32'h0); rd(A_FLG, "R3 write zero keeps");
    wr(A_FLG, 32'h0000_0010); rd(A_FLG, "R3 one clears");
    chk("R3 clear literal", bus_rdata, 32'h2440_0000);
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, "R3 enable reserved");
    chk("R3 enable literal", bus_rdata, 32'h3FCF_FFFF);
    rd(8'h52, "R3 unaligned read"); rd(8'h60, "R3 unused address");
    wr(A_FLG, 32'hFFFF_FFFF); rd(A_FLG, "R3 clear all");

    // R4 set and clear in one cycle
    src_evt = 32'h0000_0100;
    wr(A_FLG, 32'h0000_0100); src_evt = 0;
    rd(A_FLG, "R4 set wins"); chk("R4 literal", bus_rdata & 32'h100, 32'h100);
    wr(A_FLG, 32'hFFFF_FFFF);

    // R5 error code screening
    lec_arb = 3'd3; idle(1); rd(A_FLG, "R5 arb 0->3 sets");
    wr(A_FLG, 32'hFFFF_FFFF); idle(2); rd(A_FLG, "R5 arb unchanged");
    lec_arb = 3'd7; idle(1); lec_arb = 3'd0; idle(1); rd(A_FLG, "R5 codes 7 and 0 screened");
    chk("R5 screened literal", bus_rdata, 32'h0);
    lec_data = 3'd5; idle(1); rd(A_FLG, "R5 data code sets bit28");
    lec_data = 3'd2; wr(A_FLG, 32'hFFFF_FFFF); rd(A_FLG, "R5 change 5->2 sets again");
    wr(A_FLG, 32'hFFFF_FFFF);

    // R6 status change on either edge
    st_warn = 1'b1; idle(1); rd(A_FLG, "R6 warn rise"); wr(A_FLG, 32'hFFFF_FFFF);
    st_warn = 1'b0; idle(1); rd(A_FLG, "R6 warn fall");
    chk("R6 fall literal", bus_rdata, 32'h0100_0000);
    st_bus_off = 1'b1; st_passive = 1'b1; idle(1); rd(A_FLG, "R6 busoff passive");
    wr(A_FLG, 32'hFFFF_FFFF);

    // R7 zero-size write attempts
    q_wr_try = 3'b010; idle(1); q_wr_try = 0; rd(A_FLG, "R7 nonzero size ignored");
    q_size_zero = 3'b010; q_wr_try = 3'b010; idle(1); q_wr_try = 0;
    rd(A_FLG, "R7 queue1 lost"); chk("R7 literal", bus_rdata, 32'h80);
    q_size_zero = 3'b101; q_wr_try = 3'b101; idle(1); q_wr_try = 0; q_size_zero = 0;
    rd(A_FLG, "R7 queues 0 and 2");
    wr(A_FLG, 32'hFFFF_FFFF);

    // R8 transmit failure and restricted mode
    tx_mem_fail = 1'b1; idle(1); tx_mem_fail = 0;
    rd(A_FLG, "R8 fail flag"); chk("R8 flag17 literal", bus_rdata, 32'h0002_0000);
    wr(A_FLG, 32'hFFFF_FFFF); idle(3); rd(A_MODE, "R8 mode held");
    tx_mem_fail = 1'b1; wr(A_MODE, 32'h0); tx_mem_fail = 0;
    rd(A_MODE, "R8 fail beats clear"); wr(A_MODE, 32'h0); rd(A_MODE, "R8 mode cleared");
    chk("R8 cleared literal", bus_rdata, 32'h0);
    wr(A_FLG, 32'hFFFF_FFFF);

    // R9 line routing
    wr(A_EN, 32'h0000_0001); wr(A_SEL, 32'h0);
    src_evt = 32'h1; idle(1); src_evt = 0; idle(1);
    chk("R9 line0 literal", {30'h0, irq_line}, 32'h1);
    wr(A_SEL, 32'h1); idle(1);
    chk("R9 line1 literal", {30'h0, irq_line}, 32'h2);
    wr(A_FLG, 32'hFFFF_FFFF); idle(1);

    // random traffic against the model
    for (int it = 0; it < 3000; it++) begin
      logic [31:0] r;
      logic [7:0]  a;
      r = $urandom;
      src_evt = $urandom & $urandom & $urandom;
      q_wr_try = 3'($urandom & $urandom);
      if (r[3:0] == 0) q_size_zero = 3'($urandom);
      if (r[6:4] == 0) lec_arb = 3'($urandom);
      if (r[9:7] == 0) lec_data = 3'($urandom);
      if (r[13:10] == 0) st_bus_off = ~st_bus_off;
      if (r[17:14] == 1) st_warn = ~st_warn;
      if (r[21:18] == 2) st_passive = ~st_passive;
      tx_mem_fail = (r[26:22] == 0);
      case (r[29:27] % 5)
        0: a = A_FLG; 1: a = A_EN; 2: a = A_SEL; 3: a = A_MODE; default: a = 8'h44;
      endcase
      if (r[31:30] == 0 || r[31:30] == 3) begin
        rd(a, "R3 random readback");
        cycle();
      end else if (a == A_MODE && r[30]) begin
        wr(a, 32'h0);
      end else if (a != A_MODE) begin
        wr(a, $urandom);
      end else begin
        bus_sel = 1'b0;
        cycle();
      end
    end
    src_evt = 0; idle(2);
    rd(A_FLG, "R2 final flags");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule